// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Accumulate Unit

This block takes two 32-bit operand words and a 32-bit signed addend. It forms two signed 16x16 products, one from the lower halfwords of the two operand words and one from the upper halfwords. Both products and the addend are summed as one exact signed value. The result is the low 32 bits of that sum, with no clamping.

Overflow is tested once, on the complete three-term sum, which is held at 34 bits. The result overflows when it lies outside the signed 32-bit range. If the two products alone exceed that range but the addend brings the total back inside it, no overflow is reported. An overflow sets a sticky saturation flag. Only the clear input or reset returns that flag to zero.

The unit has one register stage. The result, its valid and the flag update appear one clock after a valid input.

Top module: `dual_mac16`

## Requirements
- R1: After reset, `res_vld` is 0, `res_word` is 0 and `sat_flag` is 0.
- R2: One cycle after `op_vld` is high, `res_vld` is 1. `res_vld` is 0 one cycle after a cycle in which `op_vld` is low.
- R3: The lower-half product is the signed product of `op_a[15:0]` and `op_b[15:0]`. The upper-half product is the signed product of `op_a[31:16]` and `op_b[31:16]`.
- R4: `res_word` equals the low 32 bits of the exact sum of both products and `op_acc`, with the addend taken as signed. `res_word` updates one cycle after a valid input and holds while `op_vld` is low.
- R5: Overflow is flagged only when the exact three-term sum lies outside the range -2^31 to 2^31-1. When the products alone overflow but the full sum is in range, no overflow is flagged. Example: op_a = op_b = 0x80008000 and op_acc = 0xFFFFFFFF give res_word = 0x7FFFFFFF with no overflow.
- R6: An overflowing valid operation sets `sat_flag` one cycle later. Example: op_a = op_b = 0x80008000 with op_acc = 0x7FFFFFFF.
- R7: `sat_flag` stays set through later operations that do not overflow, including all-zero operands. An all-zero operation leaves the flag unchanged.
- R8: `sat_clr` high clears `sat_flag` on the next edge, unless the operation accepted in the same cycle overflows. Overflow takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Operands valid |
| op_a | input | 32 | First operand word, two signed halfwords |
| op_b | input | 32 | Second operand word, two signed halfwords |
| op_acc | input | 32 | Signed accumulator addend |
| sat_clr | input | 1 | Clear for the sticky saturation flag |
| res_vld | output | 1 | Result valid |
| res_word | output | 32 | Low 32 bits of the exact sum |
| sat_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `op_vld` and `sat_clr` are driven to known levels in every cycle after reset. They also assume that the operands are known whenever `op_vld` is high. The bench drives every input from tasks away from the clock edge, so this always holds.

Random operands mostly stay in range. They are interleaved with directed extremes: the halfword value -32768, addends at both ends of the signed range, and the case where the products overflow but the addend brings the sum back. Clear pulses are mixed in, some in the same cycle as an overflowing operation.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int PROD_W = 2 * HALF_W;
  localparam int SUM_W  = WORD_W + 2;

  typedef logic signed [HALF_W-1:0] half_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [SUM_W-1:0]  sum_t;

  // Signed product of two halfwords.
  function automatic prod_t half_mul(input half_t x, input half_t y);
    return prod_t'(x) * prod_t'(y);
  endfunction

  // Exact three-term sum, held at SUM_W bits.
  function automatic sum_t tri_sum(input prod_t p0, input prod_t p1,
                                   input logic signed [WORD_W-1:0] acc);
    return sum_t'(p0) + sum_t'(p1) + sum_t'(acc);
  endfunction

  // True when the sum does not fit a signed WORD_W value.
  function automatic logic out_of_range(input sum_t s);
    return (s[SUM_W-1:WORD_W-1] != {(SUM_W-WORD_W+1){1'b0}}) &&
           (s[SUM_W-1:WORD_W-1] != {(SUM_W-WORD_W+1){1'b1}});
  endfunction
endpackage

// File: rtl/dmac_lane_mul.sv
module dmac_lane_mul
  import dmac_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES*HALF_W-1:0] a_in,
  input  logic [LANES*HALF_W-1:0] b_in,
  output prod_t                   prod [LANES]
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign prod[g] = half_mul(half_t'(a_in[g*HALF_W +: HALF_W]),
                              half_t'(b_in[g*HALF_W +: HALF_W]));
  end
endmodule

// File: rtl/dmac_sum_ovf.sv
module dmac_sum_ovf
  import dmac_pkg::*;
(
  input  prod_t              p_lo,
  input  prod_t              p_hi,
  input  logic [WORD_W-1:0]  acc,
  output logic [WORD_W-1:0]  low_word,
  output logic               ovf
);
  sum_t full;
  always_comb begin
    full     = tri_sum(p_lo, p_hi, acc);
    low_word = full[WORD_W-1:0];
    ovf      = out_of_range(full);
  end
endmodule

// File: rtl/dmac_qflag.sv
module dmac_qflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end
endmodule

// File: rtl/dual_mac16.sv
module dual_mac16
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_vld,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [WORD_W-1:0] op_acc,
  input  logic              sat_clr,
  output logic              res_vld,
  output logic [WORD_W-1:0] res_word,
  output logic              sat_flag
);
  prod_t             prod [2];
  logic [WORD_W-1:0] sum_low;
  logic              sum_ovf;
  logic              ovf_event;

  dmac_lane_mul #(.LANES(2)) u_mul (
    .a_in(op_a), .b_in(op_b), .prod(prod)
  );

  dmac_sum_ovf u_sum (
    .p_lo(prod[0]), .p_hi(prod[1]), .acc(op_acc),
    .low_word(sum_low), .ovf(sum_ovf)
  );

  assign ovf_event = op_vld & sum_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_word <= '0;
    end else begin
      res_vld <= op_vld;
      if (op_vld) res_word <= sum_low;
    end
  end

  dmac_qflag u_q (
    .clk(clk), .rst_n(rst_n), .set_ev(ovf_event), .clr_ev(sat_clr), .flag(sat_flag)
  );
endmodule

// File: rtl/dual_mac16_chk.sv
module dual_mac16_chk (
  input logic clk,
  input logic rst_n,
  input logic op_vld,
  input logic sat_clr,
  input logic ovf_event,
  input logic res_vld,
  input logic sat_flag
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_vld == $past(op_vld)));
  // R6
  ovf_sets_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> sat_flag);
  // R7
  q_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);
  // R8
  q_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !ovf_event) |=> !sat_flag);
  // R5
  q_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(ovf_event));
  // R5
  no_vld_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |-> !ovf_event);
endmodule

bind dual_mac16 dual_mac16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .sat_clr(sat_clr),
  .ovf_event(ovf_event), .res_vld(res_vld), .sat_flag(sat_flag)
);

// File: tb/tb_dual_mac16.sv
module tb_dual_mac16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_vld = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, op_acc = '0;
  logic sat_clr = 1'b0;
  logic res_vld;
  logic [31:0] res_word;
  logic sat_flag;

  int n_run = 0;
  int n_fail = 0;
  logic exp_q = 1'b0;
  logic [31:0] exp_word = '0;

  always #10 clk = ~clk;

  dual_mac16 dut (.*);

  function automatic longint ref_sum(input logic [31:0] a, b, c);
    longint lo, hi;
    lo = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    hi = longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
    return lo + hi + longint'($signed(c));
  endfunction

  function automatic logic ref_ovf(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  // Drive one cycle, then check the outputs after the edge.
  task automatic step(input logic v, input logic [31:0] a, b, c, input logic clr);
    longint s;
    @(negedge clk);
    op_vld = v; op_a = a; op_b = b; op_acc = c; sat_clr = clr;
    s = ref_sum(a, b, c);
    if (v && ref_ovf(s)) exp_q = 1'b1;
    else if (clr) exp_q = 1'b0;
    if (v) exp_word = s[31:0];
    @(negedge clk);
    chk("R2 valid", {31'b0, res_vld}, {31'b0, v});
    chk("R4/R3 result", res_word, exp_word);
    chk("R6/R7/R8/R5 flag", {31'b0, sat_flag}, {31'b0, exp_q});
    op_vld = 1'b0; sat_clr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 vld", {31'b0, res_vld}, 32'd0);
    chk("R1 word", res_word, 32'd0);
    chk("R1 flag", {31'b0, sat_flag}, 32'd0);
    rst_n = 1'b1;
    // R5 products overflow, addend brings the sum back
    step(1, 32'h80008000, 32'h80008000, 32'hFFFFFFFF, 0);
    chk("R5 corner word", res_word, 32'h7FFFFFFF);
    chk("R5 corner no Q", {31'b0, sat_flag}, 32'd0);
    // R3 lane separation
    step(1, 32'h0003_FFFE, 32'h0005_0007, 32'd0, 0);
    chk("R3 lanes", res_word, 32'd1);
    // R6 worst case overflow
    step(1, 32'h80008000, 32'h80008000, 32'h7FFFFFFF, 0);
    chk("R6 set", {31'b0, sat_flag}, 32'd1);
    // R7 zero operands keep the flag
    step(1, 0, 0, 0, 0);
    chk("R7 sticky", {31'b0, sat_flag}, 32'd1);
    // R4 idle cycle holds result
    step(0, 32'h1234, 32'h5678, 32'h9, 0);
    chk("R4 hold", res_word, 32'd0);
    // R8 clear
    step(0, 0, 0, 0, 1);
    chk("R8 clear", {31'b0, sat_flag}, 32'd0);
    // R8 overflow wins over clear
    step(1, 32'h80008000, 32'h80008000, 32'h7FFFFFFF, 1);
    chk("R8 priority", {31'b0, sat_flag}, 32'd1);
    step(0, 0, 0, 0, 1);
    // Negative overflow
    step(1, 32'h80007FFF, 32'h7FFF8000, 32'h80000000, 0);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b, c;
      a = $urandom; b = $urandom; c = $urandom;
      if (($urandom % 8) == 0) a = 32'h80008000;
      if (($urandom % 8) == 0) b = 32'h80008000;
      if (($urandom % 6) == 0) c = (($urandom % 2) == 0) ? 32'h7FFFFFFF : 32'h80000000;
      step(($urandom % 4) != 0, a, b, c, ($urandom % 10) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule